// File: doc/BRIEF.md
# Reference Selection and Bus Clock Divider Chain

This block derives three clock-enable streams, and the rate of each one, from a fast free-running clock. A reference source is chosen first: the crystal, the slow clock, the slow clock scaled up, or nothing. The main (core) clock is then either that reference or the output of the main PLL. The PLL is modelled as a fixed multiply ratio set by a parameter. Two integer dividers follow in cascade. The first divides the core clock down to the high-speed bus clock. The second divides the bus clock down to the peripheral bus clock.

Each stage produces two things. One is a single-cycle enable pulse on the fast clock, which downstream logic uses to step at the stage rate. The other is a computed frequency in hertz, so software can check the effective rates. A small query port returns the rate of a requested clock by identifier.

Top module: `clk_ratio_chain`

## Requirements
- R1: When `ref_sel` is any value other than 2, `ref_hz` equals the crystal rate (default 26,000,000).
- R2: When `ref_sel` is 2, `ref_hz` depends on the slow-clock bits:
  - With `slow_pll_en` clear, `ref_hz` is 0 and `core_en` stays low.
  - With `slow_pll_en` set, `ref_hz` is 32,768.
  - With both `slow_pll_en` and `slow_mul_en` set, `ref_hz` is 32,768 × 1024.
- R3: `core_hz` equals `ref_hz` when `main_bypass` is 1 or `main_pll_en` is 0. Otherwise it equals `ref_hz` × PLL_MUL (default 16).
- R4: The divider fields sit in `div_cfg`: bits [5:3] are the bus divide field m, and bits [7:6] are the peripheral divide field p.
  - `bus_hz` = `core_hz` / (1+m).
  - `per_hz` = `bus_hz` / (1+p).
  - Both divisions truncate.
- R5: `core_en` is 1 exactly while `core_hz` is nonzero.
- R6: While the core runs, `bus_en` pulses once per 1+m running cycles. `per_en` pulses once per 1+p bus pulses, and always in the same cycle as a bus pulse.
- R7: A change of `div_cfg` restarts both dividers. Neither enable pulses in the cycle after the change. Counting running cycles from the change edge, the first bus pulse comes after 1+m cycles and the first peripheral pulse after (1+m)(1+p) cycles.
- R8: `query_hz` depends on `clk_query`:
  - Identifier 1 returns `per_hz`.
  - Identifier 2 returns 32,768.
  - Identifiers 0 and 3 return 0.
- R9: While `rst_n` is low, both `bus_en` and `per_en` are 0. Both dividers restart from zero after release.
- R10: While `core_hz` is 0, no enable pulses. Both dividers hold their position and resume from it when the core runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 2 | Reference source select |
| slow_pll_en | input | 1 | Enables the slow-clock reference path |
| slow_mul_en | input | 1 | Multiplies the slow reference by 1024 |
| main_bypass | input | 1 | Core clock taken directly from the reference |
| main_pll_en | input | 1 | Main PLL enable |
| div_cfg | input | 5 | Divider fields, bits [7:3] of the post-divider byte |
| clk_query | input | 2 | Clock identifier for rate query |
| core_en | output | 1 | Core clock enable |
| bus_en | output | 1 | High-speed bus enable pulse |
| per_en | output | 1 | Peripheral bus enable pulse |
| ref_hz | output | 32 | Reference rate in Hz |
| core_hz | output | 32 | Core clock rate in Hz |
| bus_hz | output | 32 | Bus clock rate in Hz |
| per_hz | output | 32 | Peripheral clock rate in Hz |
| query_hz | output | 32 | Rate of the queried clock |

## Verification
The bench targets several corner cases, each of which a wrong design would expose:
- Reference select 2 with the slow path disabled. A design that fell back to the crystal would report 26 MHz and keep pulsing.
- Changes to the divider fields at arbitrary divider positions. A design that did not restart would emit a pulse too early, or keep the old period for one round.
- Divide-by-one on both stages. This checks that a zero field gives a pulse on every running cycle, not a stall.
- Stopping and restarting the core mid-count. A design that reset its counters on a stop, rather than holding them, would shift every later pulse.

// File: rtl/clk_ratio_chain.sv
module clk_ratio_chain #(
  parameter int unsigned XTAL_HZ  = 26000000,
  parameter int unsigned SLOW_HZ  = 32768,
  parameter int unsigned SLOW_MUL = 1024,
  parameter int unsigned PLL_MUL  = 16,
  parameter int unsigned MDIV_W   = 3,
  parameter int unsigned PDIV_W   = 2,
  parameter int unsigned MDIV_LSB = 3,
  parameter int unsigned HZ_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ref_sel,
  input  logic                 slow_pll_en,
  input  logic                 slow_mul_en,
  input  logic                 main_bypass,
  input  logic                 main_pll_en,
  input  logic [MDIV_LSB+MDIV_W+PDIV_W-1:MDIV_LSB] div_cfg,
  input  logic [1:0]           clk_query,
  output logic                 core_en,
  output logic                 bus_en,
  output logic                 per_en,
  output logic [HZ_W-1:0]      ref_hz,
  output logic [HZ_W-1:0]      core_hz,
  output logic [HZ_W-1:0]      bus_hz,
  output logic [HZ_W-1:0]      per_hz,
  output logic [HZ_W-1:0]      query_hz
);
  localparam int unsigned PDIV_LSB = MDIV_LSB + MDIV_W;
  localparam int unsigned CFG_MSB  = PDIV_LSB + PDIV_W - 1;
  localparam logic [1:0]  SEL_SLOW = 2'd2;
  localparam logic [1:0]  Q_PER    = 2'd1;
  localparam logic [1:0]  Q_SLOW   = 2'd2;

  logic [MDIV_W-1:0] mdiv, mdiv_q, bcnt;
  logic [PDIV_W-1:0] pdiv, pdiv_q, pcnt;
  logic run, chg, bwrap, pwrap;

  assign mdiv = div_cfg[PDIV_LSB-1:MDIV_LSB];
  assign pdiv = div_cfg[CFG_MSB:PDIV_LSB];

  always_comb begin
    if (ref_sel == SEL_SLOW)
      ref_hz = !slow_pll_en ? '0 :
               slow_mul_en  ? HZ_W'(SLOW_HZ * SLOW_MUL) : HZ_W'(SLOW_HZ);
    else
      ref_hz = HZ_W'(XTAL_HZ);
  end

  assign core_hz = (main_bypass || !main_pll_en) ? ref_hz : ref_hz * HZ_W'(PLL_MUL);
  assign bus_hz  = core_hz / (HZ_W'(mdiv) + HZ_W'(1));
  assign per_hz  = bus_hz / (HZ_W'(pdiv) + HZ_W'(1));

  always_comb begin
    case (clk_query)
      Q_PER:   query_hz = per_hz;
      Q_SLOW:  query_hz = HZ_W'(SLOW_HZ);
      default: query_hz = '0;
    endcase
  end

  assign run     = core_hz != '0;
  assign core_en = run;
  assign chg     = (mdiv != mdiv_q) || (pdiv != pdiv_q);
  assign bwrap   = bcnt == mdiv_q;
  assign pwrap   = pcnt == pdiv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdiv_q <= '0;
      pdiv_q <= '0;
      bcnt   <= '0;
      pcnt   <= '0;
      bus_en <= 1'b0;
      per_en <= 1'b0;
    end else if (chg) begin
      mdiv_q <= mdiv;
      pdiv_q <= pdiv;
      bcnt   <= '0;
      pcnt   <= '0;
      bus_en <= 1'b0;
      per_en <= 1'b0;
    end else if (run) begin
      bus_en <= bwrap;
      per_en <= bwrap && pwrap;
      bcnt   <= bwrap ? '0 : bcnt + 1'b1;
      if (bwrap) pcnt <= pwrap ? '0 : pcnt + 1'b1;
    end else begin
      bus_en <= 1'b0;
      per_en <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_ratio_chain_chk.sv
module clk_ratio_chain_chk #(
  parameter int unsigned SLOW_HZ = 32768,
  parameter int unsigned CFG_W   = 5,
  parameter int unsigned HZ_W    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ref_sel,
  input logic             slow_pll_en,
  input logic [CFG_W-1:0] div_cfg,
  input logic [1:0]       clk_query,
  input logic             core_en,
  input logic             bus_en,
  input logic             per_en,
  input logic [HZ_W-1:0]  ref_hz,
  input logic [HZ_W-1:0]  core_hz,
  input logic [HZ_W-1:0]  bus_hz,
  input logic [HZ_W-1:0]  per_hz,
  input logic [HZ_W-1:0]  query_hz
);
  assert_slow_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == 2'd2 && !slow_pll_en) |-> (ref_hz == '0 && !core_en));

  assert_ratio_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hz <= core_hz) && (per_hz <= bus_hz));

  assert_bus_needs_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> $past(core_en));

  assert_per_with_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> bus_en);

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && div_cfg != $past(div_cfg)) |=> (!bus_en && !per_en));

  assert_query_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_query == 2'd2) |-> (query_hz == HZ_W'(SLOW_HZ)));

  assert_query_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_query == 2'd0 || clk_query == 2'd3) |-> (query_hz == '0));
endmodule

bind clk_ratio_chain clk_ratio_chain_chk #(
  .SLOW_HZ(SLOW_HZ), .CFG_W(MDIV_W + PDIV_W), .HZ_W(HZ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .slow_pll_en(slow_pll_en),
  .div_cfg(div_cfg), .clk_query(clk_query), .core_en(core_en),
  .bus_en(bus_en), .per_en(per_en), .ref_hz(ref_hz), .core_hz(core_hz),
  .bus_hz(bus_hz), .per_hz(per_hz), .query_hz(query_hz)
);

// File: tb/test_clk_ratio_chain.sv
module test_clk_ratio_chain;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ref_sel = 2'd0, clk_query = 2'd0;
  logic slow_pll_en = 1'b0, slow_mul_en = 1'b0, main_bypass = 1'b0, main_pll_en = 1'b1;
  logic [7:3] div_cfg = 5'b01_010;
  logic core_en, bus_en, per_en;
  logic [31:0] ref_hz, core_hz, bus_hz, per_hz, query_hz;

  int checks = 0, fails = 0;
  longint n = 0;
  bit e_bus = 0, e_per = 0;
  logic [7:3] last_cfg = '0;

  always #4 clk = ~clk;

  clk_ratio_chain i_clk_ratio_chain (.*);

  function automatic longint m_ref();
    if (ref_sel != 2'd2) return 26000000;
    if (!slow_pll_en) return 0;
    return slow_mul_en ? 32768 * 1024 : 32768;
  endfunction
  function automatic longint m_core();
    return (main_bypass || !main_pll_en) ? m_ref() : m_ref() * 16;
  endfunction
  function automatic longint m_bus();
    return m_core() / (div_cfg[5:3] + 1);
  endfunction
  function automatic longint m_per();
    return m_bus() / (div_cfg[7:6] + 1);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; e_bus = 0; e_per = 0; last_cfg = '0;
    end else begin
      if (div_cfg != last_cfg) begin
        n = 0; e_bus = 0; e_per = 0;
      end else if (m_core() != 0) begin
        n++;
        e_bus = (n % (div_cfg[5:3] + 1)) == 0;
        e_per = (n % ((div_cfg[5:3] + 1) * (div_cfg[7:6] + 1))) == 0;
      end else begin
        e_bus = 0; e_per = 0;
      end
      last_cfg = div_cfg;
    end
  end

  always @(negedge clk) begin
    string ptag;
    ptag = !rst_n ? "R9" : (m_core() == 0) ? "R10" : "R6/R7";
    check(ref_sel == 2'd2 ? "R2" : "R1", ref_hz, m_ref());
    check("R3", core_hz, m_core());
    check("R4 bus", bus_hz, m_bus());
    check("R4 per", per_hz, m_per());
    check("R5", core_en, m_core() != 0);
    check({ptag, " bus_en"}, bus_en, e_bus);
    check({ptag, " per_en"}, per_en, e_per);
    check("R8", query_hz, clk_query == 2'd1 ? m_per() : clk_query == 2'd2 ? 32768 : 0);
    if (rst_n) clk_query <= clk_query + 2'd1;
  end

  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(40);
    div_cfg = 5'b00_000; step(10);
    div_cfg = 5'b11_111; step(70);
    div_cfg = 5'b10_011; step(3);
    div_cfg = 5'b01_011; step(30);
    ref_sel = 2'd2; slow_pll_en = 1'b1; step(10);
    slow_mul_en = 1'b1; step(10);
    slow_pll_en = 1'b0; step(15);
    slow_pll_en = 1'b1; step(20);
    main_bypass = 1'b1; step(10);
    main_bypass = 1'b0; main_pll_en = 1'b0; step(10);
    ref_sel = 2'd1; main_pll_en = 1'b1; step(10);
    ref_sel = 2'd3; div_cfg = 5'b11_001; step(40);
    rst_n = 1'b0; step(3);
    rst_n = 1'b1; step(30);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule